// File: doc/BRIEF.md
# Cartridge ROM and RAM Bank Mapper

This block sits between an 8-bit CPU bus with a 16-bit address and the memories on a plug-in cartridge. The lower half of the CPU address space reaches ROM: the first 16 KB always shows ROM bank 0, and the second 16 KB is a window onto any of up to 128 ROM banks of 16 KB each, giving 21-bit physical ROM addresses. An 8 KB window at A000h–BFFFh reaches either one of four 8 KB external RAM pages or one of five real-time-clock counter registers.

The cartridge has no writable memory in the ROM range, so CPU writes there program the mapper. Four 8 KB slices of that range each set one control: the RAM window enable, the ROM bank number, the shared RAM/clock select register, and a latch strobe that is passed on to the clock block. All address decoding and read-data steering is combinational. Register loads take effect on the clock edge that ends the write cycle. The clock counters themselves and the memory arrays are outside the block.

Top module: `cart_bank_mapper`

## Requirements
- R1: A CPU address in 0000h–3FFFh drives romAddr = {7'h00, cpuAddr[13:0]}, whatever the ROM bank register holds.
- R2: A write to 2000h–3FFFh loads cpuWrData[6:0] as the ROM bank number (bit 7 is dropped). A CPU address in 4000h–7FFFh drives romAddr = {bank, cpuAddr[13:0]}, where a stored bank of 0 is used as 1. After reset the stored bank is 0, so the window shows bank 1.
- R3: A read (cpuRd high) of 0000h–7FFFh returns romRdData on cpuRdData.
- R4: A write to 0000h–1FFFh whose data has low nibble Ah opens the A000h–BFFFh window, and any other value closes it. The window is closed after reset. While it is closed, reads of the window return FFh and neither ramWe nor clkWe rises.
- R5: A write to 4000h–5FFFh loads all 8 data bits into the select register, which is 00h after reset. With select 00h–03h and the window open, ramAddr = {select[1:0], cpuAddr[12:0]}, a write raises ramWe with ramWrData = cpuWrData, and a read returns ramRdData.
- R6: With select 08h–0Ch and the window open, accesses go to the clock port with clkIdx = select − 08h (0 seconds, 1 minutes, 2 hours, 3 days low, 4 days high). A write raises clkWe and never ramWe, with clkWrData = cpuWrData, and a read returns clkRdData.
- R7: With select 04h–07h or 0Dh–FFh, window reads return FFh and window writes raise neither ramWe nor clkWe.
- R8: A write to 6000h–7FFFh raises latchStrobe in that same cycle, with latchData = cpuWrData. No other access raises latchStrobe.
- R9: Reads of 8000h–9FFFh and C000h–FFFFh return FFh. Writes there change no mapper register and raise no ramWe, clkWe or latchStrobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuWr | input | 1 | Write cycle, one clock per access |
| cpuRd | input | 1 | Read cycle |
| cpuRdData | output | 8 | Read data back to the CPU |
| romAddr | output | 21 | Physical ROM address |
| romRdData | input | 8 | ROM data |
| ramAddr | output | 15 | Physical external RAM address |
| ramWrData | output | 8 | RAM write data |
| ramWe | output | 1 | RAM write enable |
| ramRdData | input | 8 | RAM data |
| clkIdx | output | 3 | Selected clock counter register |
| clkWe | output | 1 | Clock register write enable |
| clkWrData | output | 8 | Clock register write data |
| clkRdData | input | 8 | Clock register data |
| latchStrobe | output | 1 | Latch-control strobe to the clock block |
| latchData | output | 8 | Byte carried with the latch strobe |

## Verification
ROM reads are made in both halves of the ROM space with bank values 0, 5, 7Fh and 85h. These tell the fixed mapping apart from the switched one, and show both the zero-to-one substitution and the truncation of bit 7. Different bytes are written at the same offset in different RAM pages and then read back, which exposes any page aliasing. Each of the five clock selects is written and read with a distinct value, so a wrong index shows up as a swapped byte. Select values in the gaps, a closed window, and writes above the ROM range are each followed by a read, or by a look at the write enables, to show that nothing was stored.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  // Register-load and side strobes from the bus decoder to the datapath
  typedef struct packed {
    logic ldEnable;   // 0000h-1FFFh write
    logic ldRomBank;  // 2000h-3FFFh write
    logic ldSel;      // 4000h-5FFFh write
    logic latch;      // 6000h-7FFFh write
  } bankStrb_t;

endpackage

// File: rtl/cbm_ctrl.sv
module cbm_ctrl
  import cbm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic        cpuWr,
  output bankStrb_t   strb
);

  logic romSpaceWr;
  assign romSpaceWr = cpuWr && !cpuAddr[15];

  always_comb begin
    strb = '0;
    if (romSpaceWr) begin
      unique case (cpuAddr[14:13])
        2'b00: strb.ldEnable  = 1'b1;
        2'b01: strb.ldRomBank = 1'b1;
        2'b10: strb.ldSel     = 1'b1;
        default: strb.latch   = 1'b1;
      endcase
    end
  end

  AST_LATCH_ONLY_ON_WR: assert property (@(posedge clk) disable iff (!rstN)
    strb.latch |-> (cpuWr && cpuAddr[15:13] == 3'b011)); // R8

  AST_STRB_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R9

endmodule

// File: rtl/cbm_datapath.sv
module cbm_datapath
  import cbm_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int ROM_OFS_W  = 14,
  parameter int RAM_BANK_W = 2,
  parameter int RAM_OFS_W  = 13,
  parameter int SEL_W      = 8,
  parameter int CLK_FIRST  = 8,
  parameter int CLK_COUNT  = 5,
  localparam int ROM_ADDR_W = ROM_BANK_W + ROM_OFS_W,
  localparam int RAM_ADDR_W = RAM_BANK_W + RAM_OFS_W,
  localparam int CLK_IDX_W  = $clog2(CLK_COUNT)
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  bankStrb_t             strb,
  input  logic [15:0]           cpuAddr,
  input  logic [7:0]            cpuWrData,
  input  logic                  cpuWr,
  input  logic                  cpuRd,
  output logic [7:0]            cpuRdData,
  output logic [ROM_ADDR_W-1:0] romAddr,
  input  logic [7:0]            romRdData,
  output logic [RAM_ADDR_W-1:0] ramAddr,
  output logic                  ramWe,
  input  logic [7:0]            ramRdData,
  output logic [CLK_IDX_W-1:0]  clkIdx,
  output logic                  clkWe,
  input  logic [7:0]            clkRdData
);

  localparam int RAM_PAGES = 1 << RAM_BANK_W;

  logic [ROM_BANK_W-1:0] romBank;
  logic [ROM_BANK_W-1:0] effBank;
  logic [SEL_W-1:0]      selReg;
  logic                  winEn;
  logic                  inWin, inRom;
  logic                  selRam, selClk;
  logic                  ramHit, clkHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romBank <= '0;
      selReg  <= '0;
      winEn   <= 1'b0;
    end else begin
      if (strb.ldRomBank) romBank <= cpuWrData[ROM_BANK_W-1:0];
      if (strb.ldSel)     selReg  <= cpuWrData[SEL_W-1:0];
      if (strb.ldEnable)  winEn   <= (cpuWrData[3:0] == 4'hA);
    end
  end

  // ROM mapping: fixed lower half, switched upper half (0 acts as 1)
  assign effBank = (romBank == '0) ? ROM_BANK_W'(1) : romBank;
  assign romAddr = cpuAddr[14] ? {effBank, cpuAddr[ROM_OFS_W-1:0]}
                               : {{ROM_BANK_W{1'b0}}, cpuAddr[ROM_OFS_W-1:0]};

  // External window steering
  assign inRom  = !cpuAddr[15];
  assign inWin  = (cpuAddr[15:13] == 3'b101);
  assign selRam = (selReg < SEL_W'(RAM_PAGES));
  assign selClk = (selReg >= SEL_W'(CLK_FIRST)) && (selReg < SEL_W'(CLK_FIRST + CLK_COUNT));
  assign ramHit = winEn && inWin && selRam;
  assign clkHit = winEn && inWin && selClk;

  assign ramAddr = {selReg[RAM_BANK_W-1:0], cpuAddr[RAM_OFS_W-1:0]};
  assign clkIdx  = CLK_IDX_W'(selReg - SEL_W'(CLK_FIRST));
  assign ramWe   = cpuWr && ramHit;
  assign clkWe   = cpuWr && clkHit;

  always_comb begin
    cpuRdData = 8'hFF;
    if (cpuRd) begin
      if (inRom)       cpuRdData = romRdData;
      else if (ramHit) cpuRdData = ramRdData;
      else if (clkHit) cpuRdData = clkRdData;
    end
  end

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldSel |=> (selReg == $past(cpuWrData[SEL_W-1:0]))); // R5

  AST_BANK_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:14] == 2'b01) |-> (romAddr[ROM_ADDR_W-1:ROM_OFS_W] != '0)); // R2

  AST_FIXED_BANK: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:14] == 2'b00) |-> (romAddr[ROM_ADDR_W-1:ROM_OFS_W] == '0)); // R1

  AST_CLOSED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !winEn |-> (!ramWe && !clkWe)); // R4

  AST_CLOSED_READ: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !winEn && inWin) |-> (cpuRdData == 8'hFF)); // R4

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    !(ramWe && clkWe)); // R6

  AST_GAP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (!selRam && !selClk) |-> (!ramWe && !clkWe)); // R7

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  parameter int CLK_COUNT  = 5,
  localparam int ROM_ADDR_W = ROM_BANK_W + 14,
  localparam int RAM_ADDR_W = RAM_BANK_W + 13,
  localparam int CLK_IDX_W  = $clog2(CLK_COUNT)
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [15:0]           cpuAddr,
  input  logic [7:0]            cpuWrData,
  input  logic                  cpuWr,
  input  logic                  cpuRd,
  output logic [7:0]            cpuRdData,
  output logic [ROM_ADDR_W-1:0] romAddr,
  input  logic [7:0]            romRdData,
  output logic [RAM_ADDR_W-1:0] ramAddr,
  output logic [7:0]            ramWrData,
  output logic                  ramWe,
  input  logic [7:0]            ramRdData,
  output logic [CLK_IDX_W-1:0]  clkIdx,
  output logic                  clkWe,
  output logic [7:0]            clkWrData,
  input  logic [7:0]            clkRdData,
  output logic                  latchStrobe,
  output logic [7:0]            latchData
);

  bankStrb_t strb;

  cbm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuAddr (cpuAddr),
    .cpuWr   (cpuWr),
    .strb    (strb)
  );

  cbm_datapath #(
    .ROM_BANK_W (ROM_BANK_W),
    .ROM_OFS_W  (14),
    .RAM_BANK_W (RAM_BANK_W),
    .RAM_OFS_W  (13),
    .SEL_W      (8),
    .CLK_FIRST  (8),
    .CLK_COUNT  (CLK_COUNT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cpuAddr   (cpuAddr),
    .cpuWrData (cpuWrData),
    .cpuWr     (cpuWr),
    .cpuRd     (cpuRd),
    .cpuRdData (cpuRdData),
    .romAddr   (romAddr),
    .romRdData (romRdData),
    .ramAddr   (ramAddr),
    .ramWe     (ramWe),
    .ramRdData (ramRdData),
    .clkIdx    (clkIdx),
    .clkWe     (clkWe),
    .clkRdData (clkRdData)
  );

  assign ramWrData   = cpuWrData;
  assign clkWrData   = cpuWrData;
  assign latchStrobe = strb.latch;
  assign latchData   = cpuWrData;

endmodule

// File: tb/tb_cart_bank_mapper.sv
`timescale 1ns/1ps
module tb_cart_bank_mapper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic        cpuWr = 1'b0, cpuRd = 1'b0;
  logic [7:0]  cpuRdData, romRdData, ramRdData, clkRdData, ramWrData, clkWrData, latchData;
  logic [20:0] romAddr;
  logic [14:0] ramAddr;
  logic [2:0]  clkIdx;
  logic        ramWe, clkWe, latchStrobe;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  cart_bank_mapper dut (.*);

  // Memory models
  function automatic logic [7:0] romByte(input logic [20:0] a);
    return a[7:0] ^ {a[20:14], 1'b1} ^ a[13:6];
  endfunction
  assign romRdData = romByte(romAddr);

  logic [7:0] ramMem [0:255];
  logic [7:0] clkMem [0:4];
  assign ramRdData = ramMem[{ramAddr[14:13], ramAddr[5:0]}];
  assign clkRdData = (clkIdx < 3'd5) ? clkMem[clkIdx] : 8'h00;
  always @(posedge clk) begin
    if (ramWe) ramMem[{ramAddr[14:13], ramAddr[5:0]}] <= ramWrData;
    if (clkWe && clkIdx < 3'd5) clkMem[clkIdx] <= clkWrData;
  end

  // Scoreboard
  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sbQ[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cpuRd && sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      chk(it.tag, {24'h0, cpuRdData}, {24'h0, it.exp});
    end
  end

  task automatic doRead(input logic [15:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    cpuAddr = a; cpuRd = 1'b1; cpuWr = 1'b0;
    it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpuAddr = a; cpuWrData = d; cpuWr = 1'b1; cpuRd = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    cpuWr = 1'b0; cpuRd = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ramMem[i] = 8'h00;
    for (int i = 0; i < 5; i++) clkMem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // Reset state
    doRead(16'h4000, romByte(21'h04000), "R2 reset bank acts as 1");
    chk("R2 reset romAddr", {11'h0, romAddr}, 32'h04000);
    doRead(16'hA010, 8'hFF, "R4 closed after reset");
    doWrite(16'hA010, 8'h99);
    chk("R4 closed ramWe", {31'h0, ramWe}, 0);

    // ROM bank switching
    doWrite(16'h2000, 8'h05);
    doRead(16'h0123, romByte(21'h00123), "R1 fixed region read");
    chk("R1 fixed romAddr", {11'h0, romAddr}, 32'h00123);
    doRead(16'h4ABC, romByte(21'h14ABC), "R3 switched read bank 5");
    chk("R2 bank 5 romAddr", {11'h0, romAddr}, 32'h14ABC);
    doWrite(16'h3FFF, 8'h7F);
    doRead(16'h7FFF, romByte(21'h1FFFFF), "R3 top bank read");
    chk("R2 bank 7F romAddr", {11'h0, romAddr}, 32'h1FFFFF);
    doWrite(16'h2000, 8'h00);
    doRead(16'h4001, romByte(21'h04001), "R2 bank 0 acts as 1");
    doWrite(16'h2100, 8'h85);
    doRead(16'h4002, romByte(21'h14002), "R2 bit7 dropped");

    // RAM pages
    doWrite(16'h0000, 8'h1A);
    doWrite(16'h4000, 8'h00); doWrite(16'hA010, 8'h11);
    chk("R5 ramAddr page0", {17'h0, ramAddr}, 32'h0010);
    doWrite(16'h4000, 8'h01); doWrite(16'hA010, 8'h22);
    doWrite(16'h5FFF, 8'h03); doWrite(16'hBFFF, 8'h33);
    chk("R5 ramAddr page3", {17'h0, ramAddr}, 32'h7FFF);
    chk("R5 ramWe page3", {31'h0, ramWe}, 1);
    doWrite(16'h4000, 8'h00); doRead(16'hA010, 8'h11, "R5 page0 readback");
    doWrite(16'h4000, 8'h01); doRead(16'hA010, 8'h22, "R5 page1 readback");
    doWrite(16'h4000, 8'h03); doRead(16'hBFFF, 8'h33, "R5 page3 readback");

    // Clock registers
    for (int s = 8; s <= 12; s++) begin
      doWrite(16'h4000, 8'(s));
      doWrite(16'hA000, 8'(8'h40 + s));
      chk("R6 clkWe", {31'h0, clkWe}, 1);
      chk("R6 no ramWe on clock", {31'h0, ramWe}, 0);
      chk("R6 clkIdx", {29'h0, clkIdx}, 32'(s - 8));
    end
    for (int s = 12; s >= 8; s--) begin
      doWrite(16'h4000, 8'(s));
      doRead(16'hB123, 8'(8'h40 + s), "R6 clock readback");
    end

    // Gap selects
    doWrite(16'h4000, 8'h05);
    doRead(16'hA010, 8'hFF, "R7 select 05 reads FF");
    doWrite(16'hA010, 8'h77);
    chk("R7 select 05 no write", {30'h0, ramWe, clkWe}, 0);
    doWrite(16'h4000, 8'h0D);
    doRead(16'hA010, 8'hFF, "R7 select 0D reads FF");
    doWrite(16'hA010, 8'h77);
    chk("R7 select 0D no write", {30'h0, ramWe, clkWe}, 0);
    doWrite(16'h4000, 8'h88);
    doRead(16'hA010, 8'hFF, "R7 select 88 reads FF");
    doWrite(16'h4000, 8'h01); doRead(16'hA010, 8'h22, "R7 page1 untouched");

    // Disable and re-enable
    doWrite(16'h4000, 8'h00);
    doWrite(16'h1FFF, 8'h0B);
    doRead(16'hA010, 8'hFF, "R4 closed reads FF");
    doWrite(16'hA010, 8'h99);
    chk("R4 closed no ramWe", {31'h0, ramWe}, 0);
    doWrite(16'h0000, 8'hFA);
    doRead(16'hA010, 8'h11, "R4 reopen keeps data");

    // Latch strobe
    doWrite(16'h6000, 8'h01);
    chk("R8 latchStrobe", {31'h0, latchStrobe}, 1);
    chk("R8 latchData", {24'h0, latchData}, 32'h01);
    doWrite(16'h2000, 8'h02);
    chk("R8 no latch on bank write", {31'h0, latchStrobe}, 0);

    // Outside regions
    doRead(16'h8000, 8'hFF, "R9 display range reads FF");
    doRead(16'hC000, 8'hFF, "R9 work range reads FF");
    doWrite(16'h9000, 8'h55);
    chk("R9 write outside silent", {29'h0, ramWe, clkWe, latchStrobe}, 0);
    doWrite(16'hD000, 8'h07);
    doRead(16'h4003, romByte(21'h08003), "R9 bank unchanged");
    idle();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule